// File: doc/BRIEF.md
# Configurable Pixel Format Packer

This block sits between a compositor and a memory writer. Each cycle it may take one pixel with four 8-bit channels (red, green, blue, alpha) and turn it into the byte layout chosen by a 4-bit format code: 16-bit 4444 or 565, 24-bit 888, or 32-bit 8888, each with a choice of channel order. The packed bytes go into a small byte accumulator. Whole 32-bit little-endian words leave it together with a byte-strobe mask, so 16-bit pixels pair up two per word and 24-bit pixels fill three words for every four pixels.

Alpha is handled before packing. It is either kept, and optionally complemented, or it is replaced by a constant pad. A 4-bit lane mask supplies the strobes of every outgoing word. Reduced-depth channels keep the upper bits of each 8-bit input and drop the rest without rounding. Unused format codes accept pixels and discard them.

Both streams are valid/ready. A pixel transfers on a rising edge with `in_valid` and `in_ready` high. A word transfers with `out_valid` and `out_ready` high. While `out_valid` is high and `out_ready` is low, the word and strobes hold steady. `in_ready` is high whenever fewer than four bytes are waiting, or whenever the sink takes a word in the same cycle. The format, alpha and lane controls must only change while no bytes are waiting. Each run of pixels must end on a whole word: an even pixel count for 16-bit formats, and a multiple of four for 24-bit formats.

Top module: `pix_packer`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Codes 12, 13, 14 and 15 give one word per pixel. Listed from bit 31 down to bit 0, they are A,B,G,R / A,R,G,B / B,G,R,A / R,G,B,A, eight bits each.
- R3: Codes 0, 1, 2 and 3 give 16-bit pixels with channels in nibbles, listed from bit 15 down to bit 0 as A,B,G,R / A,R,G,B / B,G,R,A / R,G,B,A. Each nibble is the top four bits of its channel. Two pixels form one word, with the earlier pixel in bits 15:0.
- R4: Code 6 gives B[7:3],G[7:2],R[7:3] and code 7 gives R[7:3],G[7:2],B[7:3], from bit 15 down to bit 0. Pixels pair into words as in R3.
- R5: Code 8 gives the 24-bit value {B,G,R} and code 9 gives {R,G,B}. Their bytes are emitted least significant first, in a continuous byte stream, so four pixels fill exactly three words. Byte k of the stream goes to bits 8*(k mod 4)+7 : 8*(k mod 4) of its word.
- R6: With `alpha_keep` high, the stored alpha is the input alpha, bitwise complemented when `alpha_flip` is high.
- R7: With `alpha_keep` low, the stored alpha is 0xFF when `alpha_flip` is high and 0x00 when it is low.
- R8: `out_strb` of every emitted word equals `lane_mask`. Bit i of the mask enables bits 8i+7:8i.
- R9: Under codes 4, 5, 10 and 11, pixels are accepted and no word is emitted.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays unchanged in the next cycle. No word is lost or duplicated.
- R11: `in_ready` is high exactly when fewer than four bytes are waiting or `out_ready` is high. `out_valid` is high exactly when at least four bytes are waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel can be taken |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| in_a | input | 8 | Alpha channel |
| fmt_code | input | 4 | Output format selection |
| alpha_keep | input | 1 | Store input alpha (high) or pad (low) |
| alpha_flip | input | 1 | Complement kept alpha, or choose 0xFF pad |
| lane_mask | input | 4 | Per-byte write enables |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Sink takes the word |
| out_word | output | 32 | Packed little-endian word |
| out_strb | output | 4 | Byte strobes of the word |

## Verification
A wrong byte count in the accumulator shows up at once as a wrong `in_ready` or `out_valid` in the same cycle. It also shifts every later byte to the wrong lane, so the next emitted word mismatches the model. A wrong channel order or alpha choice changes the very next word of that format. The bench mixes stalls on both sides with every format code, so a lost or repeated word breaks the word comparison within one word time.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  localparam int CH_W       = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * CH_W;
  localparam int NB_W       = $clog2(WORD_BYTES + 1);

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_4444,
    KIND_565,
    KIND_888,
    KIND_8888
  } pix_kind_e;

  function automatic logic [NB_W-1:0] kind_bytes(input pix_kind_e k);
    case (k)
      KIND_4444, KIND_565: kind_bytes = NB_W'(2);
      KIND_888:            kind_bytes = NB_W'(3);
      KIND_8888:           kind_bytes = NB_W'(4);
      default:             kind_bytes = '0;
    endcase
  endfunction
endpackage

// File: rtl/pix_fmt_decode.sv
module pix_fmt_decode
  import pix_pack_pkg::*;
(
  input  logic [3:0]      code,
  output pix_kind_e       kind,
  output logic            red_high,
  output logic            alpha_low,
  output logic [NB_W-1:0] nbytes
);
  always_comb begin
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3:     kind = KIND_4444;
      4'd6, 4'd7:                 kind = KIND_565;
      4'd8, 4'd9:                 kind = KIND_888;
      4'd12, 4'd13, 4'd14, 4'd15: kind = KIND_8888;
      default:                    kind = KIND_NONE;
    endcase
  end

  // bit 0 picks red as the highest colour, bit 1 moves alpha to the low end
  assign red_high  = code[0];
  assign alpha_low = code[1];
  assign nbytes    = kind_bytes(kind);
endmodule

// File: rtl/pix_lane_pack.sv
module pix_lane_pack
  import pix_pack_pkg::*;
(
  input  pix_kind_e         kind,
  input  logic              red_high,
  input  logic              alpha_low,
  input  logic [CH_W-1:0]   r,
  input  logic [CH_W-1:0]   g,
  input  logic [CH_W-1:0]   b,
  input  logic [CH_W-1:0]   a,
  output logic [WORD_W-1:0] packed_le
);
  logic [CH_W-1:0] c_hi, c_lo;

  assign c_hi = red_high ? r : b;
  assign c_lo = red_high ? b : r;

  always_comb begin
    packed_le = '0;
    case (kind)
      KIND_4444: packed_le[15:0] = alpha_low ?
                   {c_hi[7:4], g[7:4], c_lo[7:4], a[7:4]} :
                   {a[7:4], c_hi[7:4], g[7:4], c_lo[7:4]};
      KIND_565:  packed_le[15:0] = {c_hi[7:3], g[7:2], c_lo[7:3]};
      KIND_888:  packed_le[23:0] = {c_hi, g, c_lo};
      KIND_8888: packed_le = alpha_low ? {c_hi, g, c_lo, a} : {a, c_hi, g, c_lo};
      default:   packed_le = '0;
    endcase
  end
endmodule

// File: rtl/pix_byte_gather.sv
module pix_byte_gather #(
  parameter int WB = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WB*8-1:0]            push_bytes,
  input  logic [$clog2(WB+1)-1:0]    push_n,
  input  logic                       pop,
  output logic [$clog2(2*WB+1)-1:0]  fill,
  output logic [WB*8-1:0]            word
);
  localparam int BB = 2 * WB;
  localparam int CW = $clog2(BB + 1);

  logic [BB*8-1:0] acc_q, acc_d, shifted, ins;
  logic [CW-1:0]   cnt_q, cnt_d, base;

  always_comb begin
    shifted = pop ? (acc_q >> (WB * 8)) : acc_q;
    base    = pop ? (cnt_q - CW'(WB)) : cnt_q;
    ins     = {{((BB - WB) * 8){1'b0}}, push_bytes} << (32'(base) * 8);
    acc_d   = push ? (shifted | ins) : shifted;
    cnt_d   = push ? (base + CW'(push_n)) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign fill = cnt_q;
  assign word = acc_q[WB*8-1:0];
endmodule

// File: rtl/pix_packer.sv
module pix_packer
  import pix_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_r,
  input  logic [7:0]  in_g,
  input  logic [7:0]  in_b,
  input  logic [7:0]  in_a,
  input  logic [3:0]  fmt_code,
  input  logic        alpha_keep,
  input  logic        alpha_flip,
  input  logic [3:0]  lane_mask,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word,
  output logic [3:0]  out_strb
);
  localparam int FILL_W = $clog2(2 * WORD_BYTES + 1);

  pix_kind_e         kind;
  logic              red_high, alpha_low;
  logic [NB_W-1:0]   nbytes;
  logic [CH_W-1:0]   alpha_eff;
  logic [WORD_W-1:0] packed_le;
  logic [FILL_W-1:0] fill_lvl;
  logic              push, pop;

  pix_fmt_decode u_dec (
    .code      (fmt_code),
    .kind      (kind),
    .red_high  (red_high),
    .alpha_low (alpha_low),
    .nbytes    (nbytes)
  );

  always_comb begin
    if (alpha_keep) alpha_eff = alpha_flip ? ~in_a : in_a;
    else            alpha_eff = {CH_W{alpha_flip}};
  end

  pix_lane_pack u_pack (
    .kind      (kind),
    .red_high  (red_high),
    .alpha_low (alpha_low),
    .r         (in_r),
    .g         (in_g),
    .b         (in_b),
    .a         (alpha_eff),
    .packed_le (packed_le)
  );

  assign out_valid = fill_lvl >= FILL_W'(WORD_BYTES);
  assign in_ready  = (fill_lvl < FILL_W'(WORD_BYTES)) | out_ready;
  assign pop       = out_valid & out_ready;
  assign push      = in_valid & in_ready & (nbytes != '0);

  pix_byte_gather #(.WB(WORD_BYTES)) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_bytes (packed_le),
    .push_n     (nbytes),
    .pop        (pop),
    .fill       (fill_lvl),
    .word       (out_word)
  );

  assign out_strb = lane_mask;
endmodule

// File: rtl/pix_packer_chk.sv
module pix_packer_chk #(
  parameter int FILL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        fmt_code,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_word,
  input logic [FILL_W-1:0] fill_lvl
);
  logic unused_code, in_fire, out_fire;
  assign unused_code = (fmt_code == 4'd4) || (fmt_code == 4'd5) ||
                       (fmt_code == 4'd10) || (fmt_code == 4'd11);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  a_r11_room_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl < FILL_W'(4)) |-> in_ready);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  a_r9_unused_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && unused_code && !out_fire) |=> $stable(fill_lvl));

  a_r2_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && fmt_code[3:2] == 2'b11 && fill_lvl == '0) |=> out_valid);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= FILL_W'(7));
endmodule

bind pix_packer pix_packer_chk #(.FILL_W(FILL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .fmt_code  (fmt_code),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .fill_lvl  (fill_lvl)
);

// File: tb/tb_pix_packer.sv
module tb_pix_packer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0, in_a = '0;
  logic [3:0] fmt_code = 4'd15;
  logic alpha_keep = 1'b1, alpha_flip = 1'b0;
  logic [3:0] lane_mask = 4'hF;
  logic out_valid, out_ready = 1'b0;
  logic [31:0] out_word;
  logic [3:0] out_strb;

  int checks = 0, fails = 0, seg_words = 0;
  logic [7:0] q[$];
  logic stalled = 1'b0;
  logic [31:0] stall_word = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pix_packer dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_pix(input [3:0] c, input [7:0] r, g, b, a, input bit keep, flip,
                                  output logic [31:0] v, output int n);
    logic [7:0] aa;
    aa = keep ? (flip ? ~a : a) : (flip ? 8'hFF : 8'h00);
    n = 0; v = '0;
    case (c)
      4'd0:  begin v = {16'h0, aa[7:4], b[7:4], g[7:4], r[7:4]}; n = 2; end
      4'd1:  begin v = {16'h0, aa[7:4], r[7:4], g[7:4], b[7:4]}; n = 2; end
      4'd2:  begin v = {16'h0, b[7:4], g[7:4], r[7:4], aa[7:4]}; n = 2; end
      4'd3:  begin v = {16'h0, r[7:4], g[7:4], b[7:4], aa[7:4]}; n = 2; end
      4'd6:  begin v = {16'h0, b[7:3], g[7:2], r[7:3]}; n = 2; end
      4'd7:  begin v = {16'h0, r[7:3], g[7:2], b[7:3]}; n = 2; end
      4'd8:  begin v = {8'h0, b, g, r}; n = 3; end
      4'd9:  begin v = {8'h0, r, g, b}; n = 3; end
      4'd12: begin v = {aa, b, g, r}; n = 4; end
      4'd13: begin v = {aa, r, g, b}; n = 4; end
      4'd14: begin v = {b, g, r, aa}; n = 4; end
      4'd15: begin v = {r, g, b, aa}; n = 4; end
      default: begin v = '0; n = 0; end
    endcase
  endfunction

  function automatic string fmt_tag(input [3:0] c, input bit keep);
    string s;
    if (c <= 4'd3) s = "R3";
    else if (c == 4'd6 || c == 4'd7) s = "R4";
    else if (c == 4'd8 || c == 4'd9) s = "R5";
    else s = "R2";
    if (c <= 4'd3 || c >= 4'd12) s = {s, keep ? " R6" : " R7"};
    return s;
  endfunction

  // one clock: drive after the falling edge, settle, predict the coming rising edge
  task automatic cycle(input bit v, input bit ordy, input [7:0] r, g, b, a, output bit took);
    logic [31:0] pv, ew;
    int pn;
    @(negedge clk);
    in_valid = v; out_ready = ordy;
    in_r = r; in_g = g; in_b = b; in_a = a;
    #1;
    if (stalled)
      check(out_valid && out_word == stall_word, "R10 held word", out_word, stall_word);
    check(out_valid == (q.size() >= 4), "R11 out_valid", 32'(out_valid), 32'(q.size() >= 4));
    check(in_ready == (q.size() < 4 || ordy), "R11 in_ready", 32'(in_ready), 32'(q.size() < 4 || ordy));
    stalled = out_valid && !ordy;
    stall_word = out_word;
    if (out_valid && ordy) begin
      seg_words++;
      if (q.size() >= 4) begin
        ew = {q[3], q[2], q[1], q[0]};
        repeat (4) void'(q.pop_front());
        check(out_word == ew, fmt_tag(fmt_code, alpha_keep), out_word, ew);
      end else
        check(1'b0, "R9 R11 unexpected word", out_word, 32'h0);
      check(out_strb == lane_mask, "R8 strobes", 32'(out_strb), 32'(lane_mask));
    end
    took = v && in_ready;
    if (took) begin
      ref_pix(fmt_code, r, g, b, a, alpha_keep, alpha_flip, pv, pn);
      for (int k = 0; k < pn; k++) q.push_back(pv[8*k +: 8]);
    end
  endtask

  task automatic drain();
    bit t;
    int guard = 0;
    while ((q.size() != 0 || out_valid) && guard < 200) begin
      cycle(1'b0, ($urandom % 4) != 0, 8'h0, 8'h0, 8'h0, 8'h0, t);
      guard++;
    end
    check(q.size() == 0, "R10 drained", 32'(q.size()), 32'h0);
  endtask

  task automatic run_seg(input [3:0] c, input bit keep, flip, input [3:0] mask,
                         input int npix, input int vpct, input int rpct);
    bit t;
    int left = npix;
    @(negedge clk);
    in_valid = 1'b0;
    fmt_code = c; alpha_keep = keep; alpha_flip = flip; lane_mask = mask;
    seg_words = 0;
    while (left > 0) begin
      cycle(($urandom % 100) < vpct, ($urandom % 100) < rpct,
            8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), t);
      if (t) left--;
    end
    drain();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit t;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'h0);
    check(in_ready, "R1 in_ready after reset", 32'(in_ready), 32'h1);
    rst_n = 1'b1;

    // directed R2: ARGB8888 literal layout, held under stall
    fmt_code = 4'd13; alpha_keep = 1'b1; alpha_flip = 1'b0; lane_mask = 4'hF;
    cycle(1'b1, 1'b0, 8'h11, 8'h22, 8'h33, 8'h44, t);
    cycle(1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, t);
    check(out_word == 32'h44112233, "R2 literal ARGB8888", out_word, 32'h44112233);
    drain();

    // directed R7: padding from flip bit, RGBA8888
    fmt_code = 4'd15; alpha_keep = 1'b0; alpha_flip = 1'b1;
    cycle(1'b1, 1'b0, 8'hA1, 8'hB2, 8'hC3, 8'h00, t);
    cycle(1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, t);
    check(out_word == 32'hA1B2C3FF, "R7 literal pad 0xFF", out_word, 32'hA1B2C3FF);
    drain();

    // directed R5: RGB888, four pixels give three words
    run_seg(4'd9, 1'b1, 1'b0, 4'hF, 4, 100, 100);
    check(seg_words == 3, "R5 four pixels three words", 32'(seg_words), 32'd3);

    // R9: unused codes emit nothing
    foreach (q[i]) q.delete(i);
    for (int c = 4; c <= 11; c++) begin
      if (c == 4 || c == 5 || c == 10 || c == 11) begin
        run_seg(4'(c), 1'b1, 1'b0, 4'hF, 7, 90, 90);
        check(seg_words == 0, "R9 no word on unused code", 32'(seg_words), 32'h0);
      end
    end

    // every valid code, every alpha mode, random masks and stalls
    for (int c = 0; c < 16; c++) begin
      if (c == 4 || c == 5 || c == 10 || c == 11) continue;
      for (int m = 0; m < 4; m++) begin
        run_seg(4'(c), m[1], m[0], 4'($urandom), 8 + 4 * ($urandom % 6),
                40 + ($urandom % 60), 30 + ($urandom % 70));
      end
    end

    // full throughput, both sides always ready
    run_seg(4'd14, 1'b1, 1'b1, 4'h5, 40, 100, 100);
    run_seg(4'd2, 1'b0, 1'b0, 4'hA, 40, 100, 100);
    run_seg(4'd8, 1'b1, 1'b0, 4'hF, 40, 100, 100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule